// File: doc/BRIEF.md
# Bounded-Waiting Lock Arbiter

This block is a hardware mutual-exclusion unit shared by N requesters. Each requester raises a request to ask for the lock, receives a one-hot grant when it owns the lock, and raises its release line to give the lock up. Internally the unit keeps a lock flag and one pending bit per requester.

When the lock is free, pending requesters compete in an atomic take-the-lock step: the lowest-numbered one wins and the lock is set in the same update. When the current owner releases, the lock is not simply freed. The unit searches the other requesters circularly, starting just after the owner. The first pending requester it finds receives the grant directly, and the lock stays set. If the search comes back round to the owner, the lock is cleared. This direct handover means that no pending requester can be passed over more than N-1 times.

Top module: `lock_handoff_arb`

## Requirements
- R1: An active-low synchronous reset clears the lock, every pending bit and every grant. After reset, no grant appears until a new request arrives.
- R2: A request from a requester that is not the owner makes it pending, and it stays pending until it is granted. A request from the current owner has no effect. A repeated request from a requester that is already pending has no effect.
- R3: While the lock is free, a pending requester is granted on the clock edge that samples its request, so the grant is visible in the next cycle. Taking the lock sets it.
- R4: When several requesters are pending while the lock is free, the lowest index wins.
- R5: When the owner h releases and another requester is pending, the grant moves in the next cycle to the first pending requester in the order h+1, h+2, …, wrapping modulo N. The lock stays held throughout, so no cycle passes with the lock free.
- R6: When the owner releases and no other requester is pending, all grants drop in the next cycle and the lock is cleared, so a later request can take it.
- R7: A release raised by a requester that does not own the lock has no effect.
- R8: At most one grant is asserted at any time.
- R9: While a requester is pending, at most N-1 grants go to other requesters before it is served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N | Per-requester lock request, sampled every cycle |
| rel | input | N | Per-requester release; acted on only for the current owner |
| grant | output | N | One-hot lock ownership, all zero when the lock is free |

## Verification
A pending bit that is lost shows at the ports as a requester that is skipped during a later circular handover. A stuck pending bit shows as a grant that no request asked for. Either fault appears at the first release that reaches that index, which is at most N releases later. A lock flag that stays set with no owner shows as a free lock that ignores every new request, which is visible in the cycle after the next request. The table of vectors therefore always follows a release by a fresh request, and it runs one complete circle with all four requesters pending.

// File: rtl/lock_arb_pkg.sv
// Package: shared types for the bounded-waiting lock arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package lock_arb_pkg;

    // Selects where the circular search begins
    typedef enum logic {
        SCAN_FROM_ZERO  = 1'b0,   // lock is free: lowest index first
        SCAN_AFTER_HOLD = 1'b1    // owner releasing: start after owner
    } scan_mode_e;

endpackage

// File: rtl/lock_ring_scan.sv
// Module: lock_ring_scan
// Finds the first set bit of a candidate vector, searching circularly
// from a start index. Purely combinational.
// Assumes: N >= 2, start < N.
module lock_ring_scan #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] pick
);

    // Walk offsets 0..N-1 from the start index and keep the first hit
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int off = 0; off < N; off++) begin
            int pos;
            pos = int'(start) + off;
            if (pos >= N) pos = pos - N;
            if (!found && cand[pos]) begin
                found = 1'b1;
                pick  = IW'(pos);
            end
        end
    end

    // Check that a reported pick names a real candidate
    always_comb begin
        if (found) begin
            pick_is_candidate_chk: assert (cand[pick])
                else $error("scan picked a non-candidate");
        end
    end

endmodule

// File: rtl/lock_wait_set.sv
// Module: lock_wait_set
// Holds one pending bit per requester. Requests from non-owners set the
// bit, and the grant controller's take vector clears it on entry.
// Assumes: take is one-hot or zero and names only candidates.
module lock_wait_set #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] grant,
    input  logic [N-1:0] take,
    output logic [N-1:0] wait_q,
    output logic [N-1:0] cand
);

    // Candidates: already pending, plus new requests from non-owners
    always_comb begin
        cand = wait_q | (req & ~grant);
    end

    // Register the pending bits and drop the one that enters
    always_ff @(posedge clk) begin
        if (!rst_n) wait_q <= '0;
        else        wait_q <= cand & ~take;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chk
            // R2
            pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wait_q[gi] && !take[gi]) |=> wait_q[gi]);
        end
    endgenerate

    // R2
    pending_not_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q & grant) == '0);

endmodule

// File: rtl/lock_grant_ctrl.sv
// Module: lock_grant_ctrl
// Owns the lock flag and the grant register. Acquires a free lock for the
// scanner's pick, or hands the lock from a releasing owner to the next
// pending requester in circular order, or clears it.
// Assumes: scanner results are combinational over cand and scan_start.
module lock_grant_ctrl
    import lock_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  rel,
    input  logic [N-1:0]  cand,
    input  logic          scan_found,
    input  logic [IW-1:0] scan_pick,
    output logic [IW-1:0] scan_start,
    output logic [N-1:0]  take,
    output logic [N-1:0]  grant_q
);

    logic          lock_q;
    logic [IW-1:0] holder;
    logic [IW-1:0] after_holder;
    logic          release_ok;
    scan_mode_e    mode;

    // Binary index of the current owner
    always_comb begin
        holder = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_q[i]) holder = IW'(i);
        end
    end

    // Release counts only from the owner; pick the scan start
    always_comb begin
        release_ok   = lock_q && ((rel & grant_q) != '0);
        after_holder = (holder == IW'(N - 1)) ? '0 : holder + IW'(1);
        mode         = release_ok ? SCAN_AFTER_HOLD : SCAN_FROM_ZERO;
        scan_start   = (mode == SCAN_AFTER_HOLD) ? after_holder : '0;
    end

    // Entry vector: one-hot for whoever gets the lock this cycle
    always_comb begin
        take = '0;
        if ((!lock_q || release_ok) && scan_found) take = N'(1) << scan_pick;
    end

    // Update lock flag and grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            grant_q <= '0;
        end else if (!lock_q) begin
            if (scan_found) begin
                lock_q  <= 1'b1;
                grant_q <= take;
            end
        end else if (release_ok) begin
            if (scan_found) begin
                grant_q <= take;
            end else begin
                lock_q  <= 1'b0;
                grant_q <= '0;
            end
        end
    end

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    // R8
    lock_matches_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q == (grant_q != '0));

    // R3
    free_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && cand != '0) |=> lock_q);

    // R5
    handoff_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_ok && scan_found) |=> (lock_q && grant_q != $past(grant_q)));

    // R6
    release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_ok && !scan_found) |=> (!lock_q && grant_q == '0));

    // R7
    foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !release_ok) |=> $stable(grant_q));

endmodule

// File: rtl/lock_handoff_arb.sv
// Module: lock_handoff_arb (top)
// Mutual-exclusion unit with direct circular handover on release, which
// bounds the wait of every pending requester.
// Assumes: N >= 2; req and rel are synchronous to clk.
module lock_handoff_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] rel,
    output logic [N-1:0] grant
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = IW + 1;

    logic [N-1:0]  wait_q;
    logic [N-1:0]  cand;
    logic [N-1:0]  take;
    logic [IW-1:0] scan_start;
    logic [IW-1:0] scan_pick;
    logic          scan_found;

    lock_wait_set #(.N(N)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .grant  (grant),
        .take   (take),
        .wait_q (wait_q),
        .cand   (cand)
    );

    lock_ring_scan #(.N(N), .IW(IW)) u_scan (
        .cand  (cand),
        .start (scan_start),
        .found (scan_found),
        .pick  (scan_pick)
    );

    lock_grant_ctrl #(.N(N), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rel        (rel),
        .cand       (cand),
        .scan_found (scan_found),
        .scan_pick  (scan_pick),
        .scan_start (scan_start),
        .take       (take),
        .grant_q    (grant)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bypass
            logic [CW-1:0] bypass_q;

            // Count entries by others while this requester is pending
            always_ff @(posedge clk) begin
                if (!rst_n)                        bypass_q <= '0;
                else if (take[gi] || !wait_q[gi])  bypass_q <= '0;
                else if (take != '0)               bypass_q <= bypass_q + CW'(1);
            end

            // R9
            bounded_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bypass_q <= CW'(N - 1));
        end
    endgenerate

endmodule

// File: tb/tb_lock_handoff_arb.sv
module tb_lock_handoff_arb;

    localparam int N  = 4;
    localparam int NV = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] rel = '0;
    logic [N-1:0] grant;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lock_handoff_arb #(.N(N)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .rel   (rel),
        .grant (grant)
    );

    // {req, rel, expected grant}, one entry per cycle; bit i = requester i
    localparam logic [11:0] VEC [NV] = '{
        {4'b0001, 4'b0000, 4'b0001},  // R3 free lock taken
        {4'b0110, 4'b0000, 4'b0001},  // R2 1,2 become pending
        {4'b0000, 4'b0001, 4'b0010},  // R5 handoff 0 -> 1
        {4'b0001, 4'b0000, 4'b0010},  // R2 0 pending
        {4'b0000, 4'b0010, 4'b0100},  // R5 handoff 1 -> 2
        {4'b0000, 4'b0100, 4'b0001},  // R5 wrap 2 -> 0
        {4'b0000, 4'b0001, 4'b0000},  // R6 nobody waiting, lock freed
        {4'b1010, 4'b0000, 4'b0010},  // R4 lowest index wins
        {4'b0000, 4'b1000, 4'b0010},  // R7 release by non-owner ignored
        {4'b0010, 4'b0010, 4'b1000},  // R2 owner re-request ignored, R5
        {4'b0000, 4'b1000, 4'b0000},  // R6
        {4'b0000, 4'b0000, 4'b0000},  // R2 owner request was not kept
        {4'b1111, 4'b0000, 4'b0001},  // R4 all request, 0 wins
        {4'b0000, 4'b0001, 4'b0010},  // R9 circle served in order
        {4'b0000, 4'b0010, 4'b0100},  // R9
        {4'b0000, 4'b0100, 4'b1000},  // R9
        {4'b0000, 4'b1000, 4'b0000}   // R6
    };
    localparam int VREQ [NV] = '{3,2,5,2,5,5,6,4,7,2,6,2,4,9,9,9,6};

    task automatic check(input int rid, input logic [N-1:0] got, input logic [N-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d: grant=%b expected=%b", rid, got, exp);
        end
        tests++;
        if ($countones(got) > 1) begin   // R8
            fails++;
            $display("FAIL R8: grant=%b expected at most one bit", got);
        end
    endtask

    // Drive one cycle of inputs at negedge, check after the next posedge
    task automatic step(input logic r, input logic [N-1:0] q, input logic [N-1:0] l,
                        input logic [N-1:0] exp, input int rid);
        rst_n = r;
        req   = q;
        rel   = l;
        @(posedge clk);
        @(negedge clk);
        check(rid, grant, exp);
    endtask

    initial begin
        @(negedge clk);
        step(1'b0, '0, '0, 4'b0000, 1);        // R1 reset state
        for (int k = 0; k < NV; k++) begin
            step(1'b1, VEC[k][11:8], VEC[k][7:4], VEC[k][3:0], VREQ[k]);
        end
        // Directed: reset while lock held and one requester pending (R1)
        step(1'b1, 4'b0100, 4'b0000, 4'b0100, 3);
        step(1'b1, 4'b0001, 4'b0000, 4'b0100, 2);
        step(1'b0, 4'b0000, 4'b0000, 4'b0000, 1);
        step(1'b1, 4'b0000, 4'b0000, 4'b0000, 1);  // R1 pending bit cleared
        step(1'b1, 4'b1000, 4'b0000, 4'b1000, 1);  // R1 lock cleared by reset
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule